// File: doc/BRIEF.md
# Pipelined Token Controller with Drain

This block sequences a multi-cycle arithmetic unit that accepts two operands over one shared input port. The unit takes seven cycles in total from the first operand to a usable result and can accept a new operand pair every four cycles. Each active state is one flip-flop holding a token, so the controller is one-hot. A start pulse places the first token in the join state. The token then walks through four steady-state stages: operand a with the load strobe high, operand b with the strobe low, and two idle stages. At the fork the token is duplicated. One copy runs through a three-stage epilogue whose last stage captures the product. The other copy goes back to the join and begins the next iteration, so up to two iterations are in flight at once.

The surrounding datapath stops issue by raising a last-operand flag in the same cycle it presents its final operand a. The back-edge token is gated off directly at the join flip-flop's input, and the iterations already started still complete. An empty flag reports when no token remains anywhere. A parameter selects between a combinational empty detector and a registered one, which reports one cycle later. A done pulse accompanies each product in issue order.

Top module: `pipe_token_ctrl`

## Requirements
- R1: After reset no token is present: `pipe_empty_o`=1, and `unit_s_o`, `res_en_o` and `done_o` are 0.
- R2: One cycle after `start_i` is sampled high, the controller enters the first load state: `unit_s_o`=1 and `sel_o`=0, so `unit_d_o` carries `op_a_i`. While issue has not been stopped, the load state recurs every N_STEADY (default 4) cycles, and at most one token is in the steady stages at any time.
- R3: In the cycle after each load state, `unit_s_o`=0 and `sel_o`=1, so `unit_d_o` carries `op_b_i`.
- R4: If `last_in_i` is high in a load cycle, that iteration is the last. No further load state occurs until the next start, and every iteration already issued still completes.
- R5: `res_en_o` is high exactly N_STEADY+N_EPI-1 (default 6) cycles after each load cycle, and `product_o` captures `unit_y_i` at the end of that cycle. `done_o` is high in the following cycle, and `product_o` holds the captured value in that cycle.
- R6: Each issued iteration produces exactly one done pulse, and the products appear in the same order in which the operand pairs were issued.
- R7: `pipe_empty_o` is 0 while any token is present. With EMPTY_REG=0 it becomes 1 in the cycle after the last `res_en_o`, which is the same cycle as the last `done_o`. With EMPTY_REG=1 it becomes 1 one cycle after that.
- R8: `last_in_i` raised in a cycle that is not a load cycle has no effect, and issue continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that injects the first token |
| last_in_i | input | 1 | Marks the current load as the final iteration |
| op_a_i | input | DATA_W | First operand from the datapath |
| op_b_i | input | DATA_W | Second operand from the datapath |
| unit_d_o | output | DATA_W | Shared operand port of the unit (mux output) |
| unit_s_o | output | 1 | Load strobe to the unit, high with operand a |
| unit_y_i | input | 2*DATA_W | Result port of the unit |
| sel_o | output | 1 | Operand select: 0 = a, 1 = b |
| res_en_o | output | 1 | Enable of the result register |
| product_o | output | 2*DATA_W | Result register |
| done_o | output | 1 | One pulse per captured product |
| pipe_empty_o | output | 1 | High when no token is present |

## Verification
The hardest condition to reach is two overlapping iterations while issue is being stopped. The stimulus has to keep the next operand pair ready exactly when each load state appears, and raise the last-operand flag in that same cycle. The bench does this by reacting at the falling edge to the load strobe it observes. It feeds the next table entry, or the final one together with the stop flag, in the same cycle. A separate run raises the stop flag during an idle steady stage to show that issue continues. A single-iteration run checks the case where the back-edge is cut on its very first trip.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } opsel_e;

    function automatic int tok_count(input int n_steady, input int n_epi);
        return n_steady + n_epi;
    endfunction
endpackage

// File: rtl/ptc_token_ring.sv
module ptc_token_ring #(
    parameter int N_STEADY = 4,
    parameter int N_EPI    = 3,
    localparam int N_TOK   = ptc_pkg::tok_count(N_STEADY, N_EPI)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             last_in_i,
    output logic [N_TOK-1:0] tok_o
);
    typedef struct packed {
        logic [N_TOK-1:0] tok;
        logic             stop;
    } ring_t;

    ring_t ring_d, ring_q;
    logic  stop_now;
    logic  back_edge;

    always_comb begin
        ring_d    = ring_q;
        // final-iteration flag only counts while the load stage holds the token
        stop_now  = ring_q.stop | (last_in_i & ring_q.tok[0]);
        // fork: last steady stage feeds both the join and the epilogue
        back_edge = ring_q.tok[N_STEADY-1] & ~stop_now;
        // join: gate sits right at the D input of the first stage
        ring_d.tok[0] = start_i | back_edge;
        for (int i = 1; i < N_TOK; i++) begin
            ring_d.tok[i] = ring_q.tok[i-1];
        end
        ring_d.stop = start_i ? 1'b0 : stop_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign tok_o = ring_q.tok;
endmodule

// File: rtl/ptc_empty_det.sv
module ptc_empty_det #(
    parameter int N_TOK     = 7,
    parameter bit EMPTY_REG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_TOK-1:0] tok_i,
    output logic             empty_o
);
    generate
        if (EMPTY_REG) begin : g_reg
            logic empty_d, empty_q;
            always_comb begin
                empty_d = ~|tok_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    empty_q <= 1'b1;
                end else begin
                    empty_q <= empty_d;
                end
            end
            assign empty_o = empty_q;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign empty_o    = ~|tok_i;
        end
    endgenerate
endmodule

// File: rtl/ptc_datapath.sv
module ptc_datapath #(
    parameter int DATA_W  = 16,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptc_pkg::opsel_e   sel_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic [PROD_W-1:0] unit_y_i,
    output logic [DATA_W-1:0] unit_d_o,
    output logic [PROD_W-1:0] product_o,
    output logic              done_o
);
    typedef struct packed {
        logic [PROD_W-1:0] prod;
        logic              done;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        unit_d_o = (sel_i == ptc_pkg::SEL_B) ? op_b_i : op_a_i;
        res_d      = res_q;
        res_d.done = capture_i;
        if (capture_i) begin
            res_d.prod = unit_y_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign product_o = res_q.prod;
    assign done_o    = res_q.done;
endmodule

// File: rtl/pipe_token_ctrl.sv
module pipe_token_ctrl #(
    parameter int DATA_W    = 16,
    parameter int N_STEADY  = 4,
    parameter int N_EPI     = 3,
    parameter bit EMPTY_REG = 1'b0,
    localparam int PROD_W   = 2 * DATA_W,
    localparam int N_TOK    = ptc_pkg::tok_count(N_STEADY, N_EPI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              last_in_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    output logic [DATA_W-1:0] unit_d_o,
    output logic              unit_s_o,
    input  logic [PROD_W-1:0] unit_y_i,
    output logic              sel_o,
    output logic              res_en_o,
    output logic [PROD_W-1:0] product_o,
    output logic              done_o,
    output logic              pipe_empty_o
);
    logic [N_TOK-1:0] tok;
    ptc_pkg::opsel_e  sel;

    ptc_token_ring #(.N_STEADY(N_STEADY), .N_EPI(N_EPI)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .last_in_i(last_in_i),
        .tok_o    (tok)
    );

    ptc_empty_det #(.N_TOK(N_TOK), .EMPTY_REG(EMPTY_REG)) u_empty (
        .clk    (clk),
        .rst_n  (rst_n),
        .tok_i  (tok),
        .empty_o(pipe_empty_o)
    );

    assign sel      = tok[1] ? ptc_pkg::SEL_B : ptc_pkg::SEL_A;
    assign sel_o    = (sel == ptc_pkg::SEL_B);
    assign unit_s_o = tok[0];
    assign res_en_o = tok[N_TOK-1];

    ptc_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .capture_i(tok[N_TOK-1]),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .unit_y_i (unit_y_i),
        .unit_d_o (unit_d_o),
        .product_o(product_o),
        .done_o   (done_o)
    );
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
    parameter int N_STEADY = 4,
    parameter int N_TOK    = 7,
    parameter int PROD_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              last_in_i,
    input logic              unit_s_o,
    input logic              sel_o,
    input logic              res_en_o,
    input logic              done_o,
    input logic              pipe_empty_o,
    input logic [PROD_W-1:0] unit_y_i,
    input logic [PROD_W-1:0] product_o,
    input logic [N_TOK-1:0]  tok
);
    logic seen_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_last_q <= 1'b0;
        end else if (start_i) begin
            seen_last_q <= 1'b0;
        end else if (last_in_i && unit_s_o) begin
            seen_last_q <= 1'b1;
        end
    end

    p_one_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok[N_STEADY-1:0]));

    p_b_after_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        unit_s_o |=> (sel_o && !unit_s_o));

    p_no_issue_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seen_last_q |-> !unit_s_o);

    p_done_after_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_en_o |=> (done_o && product_o == $past(unit_y_i)));

    p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ##1 !pipe_empty_o);
endmodule

bind pipe_token_ctrl ptc_checker #(
    .N_STEADY(N_STEADY),
    .N_TOK   (N_TOK),
    .PROD_W  (PROD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .last_in_i   (last_in_i),
    .unit_s_o    (unit_s_o),
    .sel_o       (sel_o),
    .res_en_o    (res_en_o),
    .done_o      (done_o),
    .pipe_empty_o(pipe_empty_o),
    .unit_y_i    (unit_y_i),
    .product_o   (product_o),
    .tok         (tok)
);

// File: tb/pipe_token_ctrl_tb.sv
`timescale 1ns/100ps
module pipe_token_ctrl_tb;
    localparam int DW   = 16;
    localparam int PW   = 32;
    localparam bit EREG = 1'b0;
    localparam int NV   = 8;
    localparam logic [31:0] VEC [NV] = '{
        32'h0003_0005, 32'hFFFF_FFFF, 32'h0000_1234, 32'h8000_0002,
        32'h00FF_0101, 32'h0007_0009, 32'hABCD_0010, 32'h0001_0000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, last_in = 1'b0;
    logic [DW-1:0] op_a = '0, op_b = '0;
    logic [DW-1:0] unit_d;
    logic unit_s, sel, res_en, done, empty;
    logic [PW-1:0] unit_y, product;
    int nvec = 0, nerr = 0;

    always #2.5 clk = ~clk;

    pipe_token_ctrl #(.DATA_W(DW), .EMPTY_REG(EREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .last_in_i(last_in),
        .op_a_i(op_a), .op_b_i(op_b), .unit_d_o(unit_d), .unit_s_o(unit_s),
        .unit_y_i(unit_y), .sel_o(sel), .res_en_o(res_en),
        .product_o(product), .done_o(done), .pipe_empty_o(empty)
    );

    // unit model: a on strobe, b next cycle, result valid five edges after b
    logic [DW-1:0] areg;
    logic [PW-1:0] dl [5];
    always @(posedge clk) begin
        if (unit_s) areg <= unit_d;
        if (sel) dl[0] <= {16'h0, areg} * {16'h0, unit_d};
        for (int k = 1; k < 5; k++) dl[k] <= dl[k-1];
    end
    assign unit_y = dl[4];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input int first, input int n, input bit glitch);
        int issued = 0, dones = 0, cyc = 0, lastload = 0, guard = 0;
        bit prevload = 0, quiet = 1;
        int loadcyc [NV];
        logic [31:0] expp;
        @(negedge clk);
        start = 1'b1;
        while (dones < n && guard < 200) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            guard++;
            if (prevload) chk(sel && !unit_s, "R3 sel/strobe after load", {sel, unit_s}, 2'b10);
            prevload = unit_s;
            if (unit_s) begin
                if (issued == 0) chk(cyc == 1 && !sel, "R2 first load timing", cyc, 1);
                else chk(cyc - lastload == 4, "R2 load interval", cyc - lastload, 4);
                if (issued >= n) begin
                    chk(1'b0, "R4 extra issue", issued, n);
                end else begin
                    op_a = VEC[first+issued][31:16];
                    op_b = VEC[first+issued][15:0];
                    loadcyc[issued] = cyc;
                end
                last_in = (issued == n - 1);
                issued++;
                lastload = cyc;
            end else begin
                last_in = glitch && issued == 1 && cyc == lastload + 2;
            end
            if (res_en) begin
                chk(cyc == loadcyc[dones] + 6, "R5 result enable timing", cyc, loadcyc[dones] + 6);
                chk(!empty, "R7 busy during capture", empty, 0);
            end
            if (done) begin
                expp = VEC[first+dones][31:16] * VEC[first+dones][15:0];
                chk(cyc == loadcyc[dones] + 7, "R5 done timing", cyc, loadcyc[dones] + 7);
                chk(product == expp, "R6 product in order", product, expp);
                dones++;
            end
        end
        last_in = 1'b0;
        chk(issued == n && dones == n, glitch ? "R8 stray last ignored" : "R6 one done per issue",
            {issued[15:0], dones[15:0]}, {n[15:0], n[15:0]});
        if (EREG) begin
            chk(!empty, "R7 registered empty lag", empty, 0);
            @(negedge clk);
            chk(empty, "R7 registered empty", empty, 1);
        end else begin
            chk(empty, "R7 empty with last done", empty, 1);
        end
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (unit_s || done || !empty) quiet = 0;
        end
        chk(quiet, "R4 no issue after last", {unit_s, done, empty}, 3'b001);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(empty && !unit_s && !res_en && !done, "R1 reset state",
            {empty, unit_s, res_en, done}, 4'b1000);
        run(0, 5, 1'b0);   // overlapping iterations, stop on fifth
        run(5, 1, 1'b0);   // stop flag on the very first load
        run(6, 2, 1'b1);   // stray stop flag in an idle stage
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule